// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the register front end of a multi-channel DMA memory access layer. Software reaches it through a simple word-addressed read/write port. It holds a global configuration word, an error status word, an interrupt enable word, and set/reset words for the active transmit and receive channels. It also keeps four event status words (transmit and receive end-of-buffer, and transmit and receive descriptor error), plus per-channel tables of descriptor pointers and receive buffer sizes.

The data path reports events through per-bit set inputs. Software acknowledges an event by writing ones to the bits it wants to clear. A configuration write with its top bit set first returns all status and control words (other than the configuration itself) to their reset values, and then stores the masked configuration value. Four interrupt lines are built from the status words and the enable bits.

The numbers of transmit and receive channels are parameters, each at most 32. The pointer and size windows grow and shrink with them. The block does not fetch descriptors and does not move data.

Top module: `dmac_ctrl_regs`

## Requirements
- R1: After reset the configuration word reads 0x0007C000. The error status, interrupt enable, all four active words and all four event words read 0, and all interrupt lines are low.
- R2: A write to configuration (word address 0x180) stores the written value ANDed with 0x00FFC087, so bit 31 never reads back as 1.
- R3: A configuration write with bit 31 set clears the error status (0x181), interrupt enable (0x182), transmit active set/reset (0x184/0x185), receive active set/reset (0x190/0x191) and the four event words in the same cycle as the store.
- R4: Interrupt enable keeps only bits 4:0. The transmit active words keep only bits 31:28. The receive active words keep only bits 31:30.
- R5: Writing error status (0x181) or an event word clears exactly the bits written as 1. The event words are transmit end-of-buffer 0x186, transmit descriptor error 0x187, receive end-of-buffer 0x192 and receive descriptor error 0x193.
- R6: Set input bit k ORs into bit k of its status word. A set and a clear of the same bit in one cycle leaves the bit set, and this includes the clear done by a configuration soft reset.
- R7: Transmit descriptor pointer k is at 0x1A0+k for k below the transmit count, and receive descriptor pointer k is at 0x1C0+k. Receive buffer size k is at 0x1E0+k and keeps bits 7:0. All of these store and return their values.
- R8: The pointer and size tables keep their contents through a configuration soft reset.
- R9: Reads of unmapped addresses return 0. This includes table addresses at or above the channel count and address 0x183. Writes to such addresses change nothing.
- R10: irq[0] is high when transmit end-of-buffer is nonzero and enable bit 0 is set. irq[1] does the same for receive end-of-buffer with enable bit 1. irq[2] is high when either descriptor-error word is nonzero and enable bit 2 is set. irq[3] is high when error status is nonzero and enable bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 10 | Absolute word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| err_set | input | 32 | Per-bit set of the error status word |
| tx_eob_set | input | TX_CH | Per-channel transmit end-of-buffer set |
| tx_derr_set | input | TX_CH | Per-channel transmit descriptor-error set |
| rx_eob_set | input | RX_CH | Per-channel receive end-of-buffer set |
| rx_derr_set | input | RX_CH | Per-channel receive descriptor-error set |
| irq | output | 4 | Gated interrupt lines |

## Verification
Status and enable words drive the interrupt lines combinationally. A status bit that fails to set, or that fails to clear, therefore shows on irq in the cycle after the offending edge. It also shows on reg_rdata as soon as that word is addressed. A wrong soft-reset path leaves stale enable or event bits visible on the next read, while a table that was reset when it should not have been reads back as a changed pointer. Decode faults show as nonzero data at unmapped addresses, or as a neighbouring table entry that was overwritten.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int DW = 32;
  localparam int AW = 10;
  localparam int SIZE_W = 8;
  localparam int NIRQ = 4;

  // word addresses of the single registers
  localparam logic [AW-1:0] ADR_CFG     = 10'h180;
  localparam logic [AW-1:0] ADR_ERR     = 10'h181;
  localparam logic [AW-1:0] ADR_IEN     = 10'h182;
  localparam logic [AW-1:0] ADR_TXA_SET = 10'h184;
  localparam logic [AW-1:0] ADR_TXA_CLR = 10'h185;
  localparam logic [AW-1:0] ADR_TX_EOB  = 10'h186;
  localparam logic [AW-1:0] ADR_TX_DERR = 10'h187;
  localparam logic [AW-1:0] ADR_RXA_SET = 10'h190;
  localparam logic [AW-1:0] ADR_RXA_CLR = 10'h191;
  localparam logic [AW-1:0] ADR_RX_EOB  = 10'h192;
  localparam logic [AW-1:0] ADR_RX_DERR = 10'h193;

  // table window bases
  localparam int TX_PTR_BASE = 'h1A0;
  localparam int RX_PTR_BASE = 'h1C0;
  localparam int RX_SZ_BASE  = 'h1E0;

  // field keep masks and reset values
  localparam logic [DW-1:0] CFG_KEEP  = 32'h00FF_C087;
  localparam logic [DW-1:0] CFG_INIT  = 32'h0007_C000;
  localparam logic [DW-1:0] IEN_KEEP  = 32'h0000_001F;
  localparam logic [DW-1:0] TXA_KEEP  = 32'hF000_0000;
  localparam logic [DW-1:0] RXA_KEEP  = 32'hC000_0000;
  localparam int            SRST_BIT  = 31;

  // interrupt line positions
  localparam int IRQ_TX_EOB = 0;
  localparam int IRQ_RX_EOB = 1;
  localparam int IRQ_DERR   = 2;
  localparam int IRQ_ERR    = 3;

endpackage

// File: rtl/dmac_w1c_reg.sv
module dmac_w1c_reg #(
  parameter int W     = 32,
  parameter int SET_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             wr_en,
  input  logic [W-1:0]     wdata,
  input  logic [SET_W-1:0] set_i,
  output logic [W-1:0]     q
);

  logic [W-1:0] set_ext;
  logic [W-1:0] q_nxt;
  logic         q_en;

  assign set_ext = W'(set_i);

  // next state: clear first, data-path set last so it wins
  always_comb begin
    q_nxt = q;
    if (soft_clr) begin
      q_nxt = '0;
    end else if (wr_en) begin
      q_nxt = q & ~wdata;
    end
    q_nxt = q_nxt | set_ext;
  end

  assign q_en = soft_clr | wr_en | (|set_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ext) |=> ((q & $past(set_ext)) == $past(set_ext))); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_clr) |=> ((q & $past(wdata) & ~$past(set_ext)) == '0)); // R5

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> ((q & ~$past(set_ext)) == '0)); // R3

endmodule

// File: rtl/dmac_chan_tab.sv
module dmac_chan_tab #(
  parameter int AW    = 10,
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int BASE  = 'h1A0
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic          hit,
  output logic [W-1:0]  rdata
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] off;
  logic [IW-1:0] idx;
  logic [W-1:0]  ent_q [DEPTH];

  assign off = addr - AW'(BASE);
  assign hit = (addr >= AW'(BASE)) && (off < AW'(DEPTH));
  assign idx = off[IW-1:0];

  // entries carry no reset: contents survive any reset of the block
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && hit && (idx == IW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) begin
        ent_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit && (idx == IW'(i))) begin
        rdata = ent_q[i];
      end
    end
  end

endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
  import dmac_pkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [DW-1:0]    err_set,
  input  logic [TX_CH-1:0] tx_eob_set,
  input  logic [TX_CH-1:0] tx_derr_set,
  input  logic [RX_CH-1:0] rx_eob_set,
  input  logic [RX_CH-1:0] rx_derr_set,
  output logic [NIRQ-1:0]  irq
);

  // ---------------- decode ----------------
  logic wr_cfg, wr_err, wr_ien, wr_txas, wr_txar, wr_rxas, wr_rxar;
  logic wr_txeob, wr_txde, wr_rxeob, wr_rxde, soft_rst;

  assign wr_cfg   = reg_wr && (reg_addr == ADR_CFG);
  assign wr_err   = reg_wr && (reg_addr == ADR_ERR);
  assign wr_ien   = reg_wr && (reg_addr == ADR_IEN);
  assign wr_txas  = reg_wr && (reg_addr == ADR_TXA_SET);
  assign wr_txar  = reg_wr && (reg_addr == ADR_TXA_CLR);
  assign wr_txeob = reg_wr && (reg_addr == ADR_TX_EOB);
  assign wr_txde  = reg_wr && (reg_addr == ADR_TX_DERR);
  assign wr_rxas  = reg_wr && (reg_addr == ADR_RXA_SET);
  assign wr_rxar  = reg_wr && (reg_addr == ADR_RXA_CLR);
  assign wr_rxeob = reg_wr && (reg_addr == ADR_RX_EOB);
  assign wr_rxde  = reg_wr && (reg_addr == ADR_RX_DERR);
  assign soft_rst = wr_cfg && reg_wdata[SRST_BIT];

  // ---------------- control words ----------------
  logic [DW-1:0] cfg_q, cfg_nxt;
  logic [DW-1:0] ien_q, ien_nxt;
  logic [DW-1:0] txas_q, txas_nxt, txar_q, txar_nxt;
  logic [DW-1:0] rxas_q, rxas_nxt, rxar_q, rxar_nxt;
  logic          ctl_en;

  always_comb begin
    cfg_nxt  = cfg_q;
    ien_nxt  = ien_q;
    txas_nxt = txas_q;
    txar_nxt = txar_q;
    rxas_nxt = rxas_q;
    rxar_nxt = rxar_q;
    if (soft_rst) begin
      ien_nxt  = '0;
      txas_nxt = '0;
      txar_nxt = '0;
      rxas_nxt = '0;
      rxar_nxt = '0;
    end
    if (wr_cfg)  cfg_nxt  = reg_wdata & CFG_KEEP;
    if (wr_ien)  ien_nxt  = reg_wdata & IEN_KEEP;
    if (wr_txas) txas_nxt = reg_wdata & TXA_KEEP;
    if (wr_txar) txar_nxt = reg_wdata & TXA_KEEP;
    if (wr_rxas) rxas_nxt = reg_wdata & RXA_KEEP;
    if (wr_rxar) rxar_nxt = reg_wdata & RXA_KEEP;
  end

  assign ctl_en = wr_cfg | wr_ien | wr_txas | wr_txar | wr_rxas | wr_rxar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_INIT;
      ien_q  <= '0;
      txas_q <= '0;
      txar_q <= '0;
      rxas_q <= '0;
      rxar_q <= '0;
    end else if (ctl_en) begin
      cfg_q  <= cfg_nxt;
      ien_q  <= ien_nxt;
      txas_q <= txas_nxt;
      txar_q <= txar_nxt;
      rxas_q <= rxas_nxt;
      rxar_q <= rxar_nxt;
    end
  end

  // ---------------- status words ----------------
  logic [DW-1:0] err_q, txeob_q, txde_q, rxeob_q, rxde_q;

  dmac_w1c_reg #(.W(DW), .SET_W(DW)) u_err (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .wr_en(wr_err),
    .wdata(reg_wdata), .set_i(err_set), .q(err_q));

  dmac_w1c_reg #(.W(DW), .SET_W(TX_CH)) u_txeob (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .wr_en(wr_txeob),
    .wdata(reg_wdata), .set_i(tx_eob_set), .q(txeob_q));

  dmac_w1c_reg #(.W(DW), .SET_W(TX_CH)) u_txde (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .wr_en(wr_txde),
    .wdata(reg_wdata), .set_i(tx_derr_set), .q(txde_q));

  dmac_w1c_reg #(.W(DW), .SET_W(RX_CH)) u_rxeob (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .wr_en(wr_rxeob),
    .wdata(reg_wdata), .set_i(rx_eob_set), .q(rxeob_q));

  dmac_w1c_reg #(.W(DW), .SET_W(RX_CH)) u_rxde (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .wr_en(wr_rxde),
    .wdata(reg_wdata), .set_i(rx_derr_set), .q(rxde_q));

  // ---------------- channel tables ----------------
  logic              txp_hit, rxp_hit, rxs_hit;
  logic [DW-1:0]     txp_rd, rxp_rd;
  logic [SIZE_W-1:0] rxs_rd;

  dmac_chan_tab #(.AW(AW), .W(DW), .DEPTH(TX_CH), .BASE(TX_PTR_BASE)) u_txptr (
    .clk(clk), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(txp_hit), .rdata(txp_rd));

  dmac_chan_tab #(.AW(AW), .W(DW), .DEPTH(RX_CH), .BASE(RX_PTR_BASE)) u_rxptr (
    .clk(clk), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(rxp_hit), .rdata(rxp_rd));

  dmac_chan_tab #(.AW(AW), .W(SIZE_W), .DEPTH(RX_CH), .BASE(RX_SZ_BASE)) u_rxsz (
    .clk(clk), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata[SIZE_W-1:0]),
    .hit(rxs_hit), .rdata(rxs_rd));

  // ---------------- read mux ----------------
  always_comb begin
    unique case (reg_addr)
      ADR_CFG:     reg_rdata = cfg_q;
      ADR_ERR:     reg_rdata = err_q;
      ADR_IEN:     reg_rdata = ien_q;
      ADR_TXA_SET: reg_rdata = txas_q;
      ADR_TXA_CLR: reg_rdata = txar_q;
      ADR_TX_EOB:  reg_rdata = txeob_q;
      ADR_TX_DERR: reg_rdata = txde_q;
      ADR_RXA_SET: reg_rdata = rxas_q;
      ADR_RXA_CLR: reg_rdata = rxar_q;
      ADR_RX_EOB:  reg_rdata = rxeob_q;
      ADR_RX_DERR: reg_rdata = rxde_q;
      default: begin
        if (txp_hit)      reg_rdata = txp_rd;
        else if (rxp_hit) reg_rdata = rxp_rd;
        else if (rxs_hit) reg_rdata = DW'(rxs_rd);
        else              reg_rdata = '0;
      end
    endcase
  end

  // ---------------- interrupts ----------------
  always_comb begin
    irq             = '0;
    irq[IRQ_TX_EOB] = ien_q[IRQ_TX_EOB] && (|txeob_q);
    irq[IRQ_RX_EOB] = ien_q[IRQ_RX_EOB] && (|rxeob_q);
    irq[IRQ_DERR]   = ien_q[IRQ_DERR]   && ((|txde_q) || (|rxde_q));
    irq[IRQ_ERR]    = ien_q[IRQ_ERR]    && (|err_q);
  end

  // ---------------- assertions ----------------
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q & ~CFG_KEEP) == '0)); // R2

  AST_SOFT_RST_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ien_q == '0 && txas_q == '0 && rxar_q == '0)); // R3

  AST_IEN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien_q & ~IEN_KEEP) == '0 && (rxas_q & ~RXA_KEEP) == '0)); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 10'h183) |-> (reg_rdata == '0)); // R9

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> (|ien_q[NIRQ-1:0])); // R10

endmodule

// File: tb/dmac_ctrl_regs_tb_top.sv
module dmac_ctrl_regs_tb_top;

  localparam int TX_CH = 4;
  localparam int RX_CH = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [9:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [31:0]      err_set = '0;
  logic [TX_CH-1:0] tx_eob_set = '0;
  logic [TX_CH-1:0] tx_derr_set = '0;
  logic [RX_CH-1:0] rx_eob_set = '0;
  logic [RX_CH-1:0] rx_derr_set = '0;
  logic [3:0]       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dmac_ctrl_regs #(.TX_CH(TX_CH), .RX_CH(RX_CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_set(err_set),
    .tx_eob_set(tx_eob_set), .tx_derr_set(tx_derr_set),
    .rx_eob_set(rx_eob_set), .rx_derr_set(rx_derr_set), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic irq_check(input string req, input logic [3:0] exp);
    @(negedge clk);
    #1;
    check(req, {28'd0, irq}, {28'd0, exp});
  endtask

  // pulse data-path set inputs for one edge
  task automatic pulse(input logic [31:0] e, input logic [3:0] te, input logic [3:0] td,
                       input logic [1:0] re, input logic [1:0] rd);
    @(negedge clk);
    err_set = e; tx_eob_set = te; tx_derr_set = td; rx_eob_set = re; rx_derr_set = rd;
    @(negedge clk);
    err_set = '0; tx_eob_set = '0; tx_derr_set = '0; rx_eob_set = '0; rx_derr_set = '0;
  endtask

  task automatic t_reset;
    rd_check("R1 cfg", 10'h180, 32'h0007_C000);
    rd_check("R1 err", 10'h181, 32'h0);
    rd_check("R1 ien", 10'h182, 32'h0);
    rd_check("R1 txas", 10'h184, 32'h0);
    rd_check("R1 rxar", 10'h191, 32'h0);
    rd_check("R1 txeob", 10'h186, 32'h0);
    rd_check("R1 rxde", 10'h193, 32'h0);
    irq_check("R1 irq", 4'h0);
  endtask

  task automatic t_cfg_mask;
    wr(10'h180, 32'h7FFF_FFFF);
    rd_check("R2 cfg all", 10'h180, 32'h00FF_C087);
    wr(10'h180, 32'h1234_5678);
    rd_check("R2 cfg pattern", 10'h180, 32'h0034_4000);
  endtask

  task automatic t_field_masks;
    wr(10'h182, 32'hFFFF_FFFF);
    rd_check("R4 ien", 10'h182, 32'h0000_001F);
    wr(10'h184, 32'hFFFF_FFFF);
    rd_check("R4 txas", 10'h184, 32'hF000_0000);
    wr(10'h185, 32'h5FFF_FFFF);
    rd_check("R4 txar", 10'h185, 32'h5000_0000);
    wr(10'h190, 32'hFFFF_FFFF);
    rd_check("R4 rxas", 10'h190, 32'hC000_0000);
    wr(10'h191, 32'h7FFF_FFFF);
    rd_check("R4 rxar", 10'h191, 32'h4000_0000);
    wr(10'h182, 32'h0);
  endtask

  task automatic t_w1c;
    pulse(32'h0000_00A5, 4'b1011, 4'b0000, 2'b00, 2'b11);
    rd_check("R6 txeob set", 10'h186, 32'h0000_000B);
    rd_check("R6 rxde set", 10'h193, 32'h0000_0003);
    rd_check("R6 err set", 10'h181, 32'h0000_00A5);
    wr(10'h186, 32'h0000_0003);
    rd_check("R5 txeob w1c", 10'h186, 32'h0000_0008);
    wr(10'h193, 32'h0000_0001);
    rd_check("R5 rxde w1c", 10'h193, 32'h0000_0002);
    wr(10'h181, 32'h0000_000F);
    rd_check("R5 err w1c", 10'h181, 32'h0000_00A0);
  endtask

  task automatic t_set_wins;
    pulse(32'h0, 4'b0000, 4'b0010, 2'b00, 2'b00);
    rd_check("R6 txde set", 10'h187, 32'h0000_0002);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'h187; reg_wdata = 32'h0000_0006; tx_derr_set = 4'b0010;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; tx_derr_set = '0;
    rd_check("R6 set beats clear", 10'h187, 32'h0000_0002);
    wr(10'h187, 32'h0000_0002);
    rd_check("R5 txde cleared", 10'h187, 32'h0);
  endtask

  task automatic t_tables;
    for (int i = 0; i < TX_CH; i++) wr(10'h1A0 + 10'(i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < RX_CH; i++) wr(10'h1C0 + 10'(i), 32'hB000_0010 + 32'(i));
    wr(10'h1E0, 32'h0000_0077);
    wr(10'h1E1, 32'h0001_2345);
    for (int i = 0; i < TX_CH; i++) rd_check("R7 txptr", 10'h1A0 + 10'(i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < RX_CH; i++) rd_check("R7 rxptr", 10'h1C0 + 10'(i), 32'hB000_0010 + 32'(i));
    rd_check("R7 rxsz0", 10'h1E0, 32'h0000_0077);
    rd_check("R7 rxsz1 masked", 10'h1E1, 32'h0000_0045);
  endtask

  task automatic t_unmapped;
    wr(10'h1A4, 32'hFFFF_FFFF);
    wr(10'h183, 32'hFFFF_FFFF);
    rd_check("R9 txptr beyond", 10'h1A4, 32'h0);
    rd_check("R9 rxptr beyond", 10'h1C2, 32'h0);
    rd_check("R9 rxsz beyond", 10'h1E2, 32'h0);
    rd_check("R9 hole", 10'h183, 32'h0);
    rd_check("R9 neighbour intact", 10'h1A3, 32'hA000_0003);
    rd_check("R9 ien untouched", 10'h182, 32'h0);
  endtask

  task automatic t_soft_reset;
    wr(10'h182, 32'h0000_001F);
    wr(10'h184, 32'hF000_0000);
    wr(10'h191, 32'hC000_0000);
    pulse(32'h0000_0100, 4'b0001, 4'b0000, 2'b01, 2'b00);
    wr(10'h180, 32'h8000_0001);
    rd_check("R2 cfg after srst", 10'h180, 32'h0000_0001);
    rd_check("R3 ien", 10'h182, 32'h0);
    rd_check("R3 txas", 10'h184, 32'h0);
    rd_check("R3 rxar", 10'h191, 32'h0);
    rd_check("R3 txeob", 10'h186, 32'h0);
    rd_check("R3 rxeob", 10'h192, 32'h0);
    rd_check("R3 rxde", 10'h193, 32'h0);
    rd_check("R3 err", 10'h181, 32'h0);
    rd_check("R8 txptr kept", 10'h1A2, 32'hA000_0002);
    rd_check("R8 rxptr kept", 10'h1C1, 32'hB000_0011);
    rd_check("R8 rxsz kept", 10'h1E1, 32'h0000_0045);
    // soft reset with a simultaneous set keeps the set bit
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'h180; reg_wdata = 32'h8000_0000; rx_eob_set = 2'b10;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; rx_eob_set = '0;
    rd_check("R6 set beats soft reset", 10'h192, 32'h0000_0002);
    wr(10'h192, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    pulse(32'h0, 4'b0000, 4'b0000, 2'b01, 2'b00);
    irq_check("R10 gated off", 4'b0000);
    wr(10'h182, 32'h0000_0002);
    irq_check("R10 rx eob", 4'b0010);
    pulse(32'h0000_0004, 4'b0000, 4'b0000, 2'b00, 2'b00);
    irq_check("R10 err masked", 4'b0010);
    wr(10'h182, 32'h0000_000A);
    irq_check("R10 err enabled", 4'b1010);
    pulse(32'h0, 4'b0000, 4'b0001, 2'b00, 2'b00);
    irq_check("R10 derr masked", 4'b1010);
    wr(10'h182, 32'h0000_000F);
    irq_check("R10 derr enabled", 4'b1110);
    pulse(32'h0, 4'b0100, 4'b0000, 2'b00, 2'b00);
    irq_check("R10 tx eob", 4'b1111);
    wr(10'h192, 32'hFFFF_FFFF);
    irq_check("R10 rx eob cleared", 4'b1101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_cfg_mask();
    t_field_masks();
    t_w1c();
    t_set_wins();
    t_tables();
    t_unmapped();
    t_soft_reset();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule